// File: doc/BRIEF.md
# Flash-to-RAM Overlay Remapper

This block lets software try out new contents for one flash erase block by serving that block from RAM. An 8-bit control register holds three settings. The first is an overlay enable. The second is a 3-bit code that picks one of eight 4-kbyte flash erase blocks at the bottom of the address map. The third is a reserved read/write bit.

While the overlay is on, every CPU address that falls inside the chosen block is redirected to a fixed 4-kbyte RAM window. The redirected address is the RAM base with the low 12 address bits kept. Every other address passes through to flash unchanged.

Turning the overlay on also locks the whole flash against programming. Every program or erase request is then answered with a one-cycle rejection pulse instead of an acceptance pulse. The translated address is registered, so a lookup appears on the outputs one cycle after it is presented.

Top module: `flash_overlay_remap`

## Requirements
- R1: Control bits 7 to 5 always read back as 0, whatever value was written to them.
- R2: Control bit 4 is a reserved bit. It reads back the last value written to it and has no effect on translation or protection.
- R3: Control bit 3 is the overlay enable. While it is 1, lookups inside the selected block are reported with `xl_ram`=1.
- R4: Control bits 2 to 0 hold a code n. While the enable is 1, an address in the range n*0x1000 to n*0x1000+0xFFF is translated to `RAM_BASE` + (address & 0xFFF).
- R5: While the enable is 1, each cycle with `pe_req`=1 gives `pe_reject`=1 on the following cycle and `pe_accept`=0.
- R6: After reset, the control register reads 0x00, the overlay is off, and all outputs are 0.
- R7: While the enable is 0, the area code has no effect: every address passes through unchanged with `xl_ram`=0.
- R8: While the enable is 1, any address outside the selected block passes through unchanged with `xl_ram`=0. This includes addresses above 0x7FFF whose bits 14 to 12 equal the code.
- R9: A register write takes effect on the clock edge that accepts it. A lookup presented in the same cycle as the write still uses the old setting. A lookup presented one cycle later uses the new setting. The translated result appears one cycle after the lookup is presented.
- R10: While the enable is 0, each cycle with `pe_req`=1 gives `pe_accept`=1 on the following cycle and `pe_reject`=0. Both flags fall back to 0 one cycle after the request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Control register read value |
| cpu_valid | input | 1 | A lookup is presented this cycle |
| cpu_addr | input | ADDR_W | CPU address to translate |
| xl_valid | output | 1 | Registered lookup result is valid |
| xl_ram | output | 1 | 1: result is redirected to RAM; 0: result targets flash |
| xl_addr | output | ADDR_W | Translated address |
| pe_req | input | 1 | Program/erase request |
| pe_accept | output | 1 | Request was allowed (one cycle later) |
| pe_reject | output | 1 | Request was refused because flash is locked (one cycle later) |

## Verification
The bench builds the block with a 24-bit address and its RAM base at 0xFFE000. With 24 address bits, the bench can probe addresses such as 0x013000. Those addresses lie above the 32-kbyte flash region but have the selected code in bits 14 to 12, which shows that the whole upper address field is compared and not just the 3 code bits. The high RAM base gives a translated address that cannot be mistaken for a pass-through value. The bench also covers all eight area codes at both edges of each block, and it times write-versus-lookup ordering cycle by cycle.

// File: rtl/flash_overlay_remap.sv
module flash_overlay_remap #(
  parameter int ADDR_W = 24,
  parameter int BLK_W  = 12,
  parameter int SEL_W  = 3,
  parameter logic [ADDR_W-1:0] RAM_BASE = 24'hFFE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              xl_valid,
  output logic              xl_ram,
  output logic [ADDR_W-1:0] xl_addr,
  input  logic              pe_req,
  output logic              pe_accept,
  output logic              pe_reject
);
  localparam int TAG_W = ADDR_W - BLK_W;
  localparam int PAD_W = 8 - 2 - SEL_W;

  logic             rsv_q;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_q <= 1'b0;
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (reg_wr_en) begin
      rsv_q <= reg_wdata[SEL_W+1];
      en_q  <= reg_wdata[SEL_W];
      sel_q <= reg_wdata[SEL_W-1:0];
    end
  end

  assign reg_rdata = {{PAD_W{1'b0}}, rsv_q, en_q, sel_q};

  logic              hit;
  logic [ADDR_W-1:0] next_addr;

  assign hit       = en_q && (cpu_addr[ADDR_W-1:BLK_W] == TAG_W'(sel_q));
  assign next_addr = hit ? {RAM_BASE[ADDR_W-1:BLK_W], cpu_addr[BLK_W-1:0]} : cpu_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid <= 1'b0;
      xl_ram   <= 1'b0;
      xl_addr  <= '0;
    end else begin
      xl_valid <= cpu_valid;
      xl_ram   <= cpu_valid && hit;
      xl_addr  <= cpu_valid ? next_addr : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_accept <= 1'b0;
      pe_reject <= 1'b0;
    end else begin
      pe_accept <= pe_req && !en_q;
      pe_reject <= pe_req && en_q;
    end
  end

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:SEL_W+2] == '0);

  p_ram_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xl_ram |-> xl_addr[ADDR_W-1:BLK_W] == RAM_BASE[ADDR_W-1:BLK_W]);

  p_lock_rejects_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req && en_q |=> pe_reject && !pe_accept);

  p_off_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !en_q |=> !xl_ram && xl_addr == $past(cpu_addr));

  p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(pe_accept && pe_reject));

  p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_req |=> !pe_accept && !pe_reject);
endmodule

// File: tb/flash_overlay_remap_tb_top.sv
module flash_overlay_remap_tb_top;
  localparam int AW = 24;
  localparam logic [AW-1:0] RB = 24'hFFE000;

  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0; logic [7:0] reg_wdata = 0; logic [7:0] reg_rdata;
  logic cpu_valid = 0; logic [AW-1:0] cpu_addr = 0;
  logic xl_valid, xl_ram; logic [AW-1:0] xl_addr;
  logic pe_req = 0; logic pe_accept, pe_reject;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  flash_overlay_remap #(.ADDR_W(AW), .RAM_BASE(RB)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(logic [7:0] d);
    reg_wr_en = 1; reg_wdata = d; tick(); reg_wr_en = 0;
  endtask

  task automatic look(string req, logic [AW-1:0] a, logic eram, logic [AW-1:0] eaddr);
    cpu_valid = 1; cpu_addr = a; tick(); cpu_valid = 0;
    chk({req, " valid"}, 32'(xl_valid), 1);
    chk({req, " ram"}, 32'(xl_ram), 32'(eram));
    chk({req, " addr"}, 32'(xl_addr), 32'(eaddr));
  endtask

  task automatic t_reset();
    chk("R6 rdata", 32'(reg_rdata), 0);
    chk("R6 flags", {xl_valid, xl_ram, pe_accept, pe_reject}, 0);
    chk("R6 addr", 32'(xl_addr), 0);
    look("R6 off", 24'h000123, 0, 24'h000123);
  endtask

  task automatic t_regbits();
    wr(8'hE0); chk("R1 rsv high", 32'(reg_rdata), 0);
    wr(8'hFB); chk("R1 R2 mask", 32'(reg_rdata), 32'h1B);
    wr(8'h10); chk("R2 hold", 32'(reg_rdata), 32'h10);
    look("R2 no effect", 24'h000456, 0, 24'h000456);
    pe_req = 1; tick(); pe_req = 0;
    chk("R2 accept", 32'(pe_accept), 1);
    wr(8'h00);
  endtask

  task automatic t_disabled();
    wr(8'h05);
    look("R7 sel ignored", 24'h005123, 0, 24'h005123);
    pe_req = 1; tick(); pe_req = 0;
    chk("R10 accept", 32'(pe_accept), 1); chk("R10 no reject", 32'(pe_reject), 0);
    tick();
    chk("R10 fall", {pe_accept, pe_reject}, 0);
  endtask

  task automatic t_blocks();
    for (int n = 0; n < 8; n++) begin
      wr(8'(8 | n));
      look("R4 low edge", AW'(n * 4096), 1, RB);
      look("R4 high edge", AW'(n * 4096 + 4095), 1, RB | 24'hFFF);
      look("R8 next blk", AW'(((n + 1) % 8) * 4096 + 7), 0, AW'(((n + 1) % 8) * 4096 + 7));
    end
  endtask

  task automatic t_enable_alias();
    wr(8'h0B);
    look("R3 mid", 24'h003ABC, 1, RB | 24'hABC);
    look("R8 alias high", 24'h013000, 0, 24'h013000);
    look("R8 far", 24'h803ABC, 0, 24'h803ABC);
  endtask

  task automatic t_lock();
    wr(8'h0E);
    pe_req = 1; tick();
    chk("R5 reject", 32'(pe_reject), 1); chk("R5 no accept", 32'(pe_accept), 0);
    tick(); pe_req = 0;
    chk("R5 held", 32'(pe_reject), 1);
    tick();
    chk("R5 pulse end", {pe_accept, pe_reject}, 0);
  endtask

  task automatic t_timing();
    wr(8'h00);
    reg_wr_en = 1; reg_wdata = 8'h0A; cpu_valid = 1; cpu_addr = 24'h002010;
    tick(); reg_wr_en = 0;
    chk("R9 old setting", 32'(xl_ram), 0);
    chk("R9 old addr", 32'(xl_addr), 32'h002010);
    tick(); cpu_valid = 0;
    chk("R9 new setting", 32'(xl_ram), 1);
    chk("R9 new addr", 32'(xl_addr), 32'(RB | 24'h010));
    tick();
    chk("R9 valid drop", 32'(xl_valid), 0);
  endtask

  initial begin
    #1; t_reset_pre();
    repeat (3) @(posedge clk); #1; rst_n = 1;
    t_reset(); t_regbits(); t_disabled(); t_blocks(); t_enable_alias(); t_lock(); t_timing();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic t_reset_pre();
    chk("R6 in reset", 32'(reg_rdata), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule